// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Hidden and Forced Cycles

This block decides when a DRAM row gets refreshed. It takes a slow periodic refresh clock, and each rising edge of that clock arms one pending refresh. While the refresh clock stays high, the block waits for a bus cycle in which the memory is not selected (chip select high) and the access strobe falls. It then uses that cycle as a hidden refresh. The row counter is steered onto the address path and the RAS enable follows the strobe, so the processor never stalls.

If the refresh clock falls while a refresh is still pending, the block pulls its refresh-request output low. The system answers by pulling the acknowledge input low. The block then runs a forced refresh: a self-timed RAS pulse of `FORCE_CYC` clock cycles. After every refresh, hidden or forced, the 7-bit row counter advances by one and wraps around. One refresh happens per refresh-clock period. When the memory is deselected and no refresh is running, the RAS enable stays high and the address-output enable is off.

The refresh clock is sampled synchronously. It passes through two flops before any edge is acted on.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `refresh_req_n` and `ras_n` are 1, `addr_sel` and `addr_oe` are 0, and `row` is 0 (with `cs_n` high).
- R2: When the synchronized refresh clock is high, a refresh is pending, `cs_n` is 1 and `acc_stb_n` falls, a hidden refresh begins in that same cycle. `addr_sel` is 1, `addr_oe` is 1 and `ras_n` equals `acc_stb_n`.
- R3: The pending flag clears when a refresh starts. A second deselected strobe in the same refresh-clock period does not refresh, and no request follows when the clock falls.
- R4: A hidden refresh still running when the refresh clock falls continues until the strobe returns high. No request is raised for that period.
- R5: `refresh_req_n` goes to 0 once the synchronized refresh clock is low with a refresh still pending. This is at the second clock edge after the fall. It is never low while the synchronized clock is high.
- R6: With `refresh_req_n` at 0, `refresh_ack_n` at 0 starts a forced refresh at the next clock edge. `ras_n` is 0 and `addr_sel` is 1 for exactly `FORCE_CYC` cycles, and `refresh_req_n` returns to 1 from that edge.
- R7: `row` increases by one, modulo 128, at the clock edge that ends each refresh. A hidden refresh ends at the first edge that samples the strobe high; a forced refresh ends at the last edge of its pulse. `row` never changes otherwise.
- R8: With `cs_n` at 1 and no refresh running, `ras_n` is 1 and `addr_oe` is 0 whatever `acc_stb_n` does.
- R9: With `cs_n` at 0 and no refresh running, `ras_n` follows `acc_stb_n`, `addr_oe` is 1 and `addr_sel` is 0.
- R10: `refresh_ack_n` at 0 while no request is outstanding has no effect: `ras_n`, `addr_sel` and `row` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_clk | input | 1 | Periodic refresh clock, sampled synchronously |
| cs_n | input | 1 | Memory chip select, active low |
| acc_stb_n | input | 1 | Bus access strobe, active low |
| refresh_ack_n | input | 1 | System acknowledge for a forced refresh, active low |
| refresh_req_n | output | 1 | Forced-refresh request, active low |
| row | output | 7 | Refresh row counter |
| addr_sel | output | 1 | 1 selects the row counter onto the address path |
| addr_oe | output | 1 | Address-output enable |
| ras_n | output | 1 | RAS enable, active low |

## Verification
Each result is due at a known cycle after its stimulus:
- **Strobe-driven outputs** (`ras_n`, `addr_sel`, `addr_oe`) respond in the same cycle as the strobe, so the bench checks them one nanosecond after it drives the strobe.
- **Pending flag:** a change of `refresh_clk` reaches it after three edges, so the bench waits four cycles before counting on it.
- **Request output:** `refresh_req_n` is due after the second edge following the clock fall, and the bench samples it after the third.
- **Row counter and forced pulse:** `row` and the start of a forced pulse are due one edge after the strobe rise or the acknowledge. The bench samples them just after that edge, then counts the forced pulse's low cycles at successive falling edges.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W     = 7,
  parameter int FORCE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_clk,
  input  logic             cs_n,
  input  logic             acc_stb_n,
  input  logic             refresh_ack_n,
  output logic             refresh_req_n,
  output logic [ROW_W-1:0] row,
  output logic             addr_sel,
  output logic             addr_oe,
  output logic             ras_n
);
  localparam int CNT_W = $clog2(FORCE_CYC + 1);

  logic rf_meta, rf_sync, rf_last;
  logic pend, hid, frc;
  logic [CNT_W-1:0] fcnt;
  logic rf_rise, start_hid, start_frc, hid_now, frc_last, hid_end;

  assign rf_rise   = rf_sync & ~rf_last;
  assign start_hid = rf_sync & pend & cs_n & ~acc_stb_n & ~hid & ~frc;
  assign start_frc = pend & ~rf_sync & ~hid & ~frc & ~refresh_ack_n;
  assign hid_now   = hid | start_hid;
  assign frc_last  = frc && (fcnt == CNT_W'(FORCE_CYC - 1));
  assign hid_end   = hid & acc_stb_n;

  assign refresh_req_n = ~(pend & ~rf_sync & ~hid & ~frc);
  assign addr_sel      = hid_now | frc;
  assign addr_oe       = hid_now | frc | ~cs_n;
  assign ras_n         = frc ? 1'b0 : ((hid_now | ~cs_n) ? acc_stb_n : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_meta <= 1'b0;
      rf_sync <= 1'b0;
      rf_last <= 1'b0;
    end else begin
      rf_meta <= refresh_clk;
      rf_sync <= rf_meta;
      rf_last <= rf_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pend <= 1'b0;
    else if (start_hid || start_frc)  pend <= 1'b0;
    else if (rf_rise)                 pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hid <= 1'b0;
    else if (start_hid) hid <= 1'b1;
    else if (hid_end)   hid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc  <= 1'b0;
      fcnt <= '0;
    end else if (start_frc) begin
      frc  <= 1'b1;
      fcnt <= '0;
    end else if (frc_last) begin
      frc  <= 1'b0;
    end else if (frc) begin
      fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   row <= '0;
    else if (hid_end || frc_last) row <= row + 1'b1;
  end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int ROW_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rf_sync,
  input logic             pend,
  input logic             hid,
  input logic             hid_now,
  input logic             frc,
  input logic             cs_n,
  input logic             acc_stb_n,
  input logic             refresh_ack_n,
  input logic             refresh_req_n,
  input logic [ROW_W-1:0] row,
  input logic             addr_sel,
  input logic             addr_oe,
  input logic             ras_n
);
  // R5
  req_low_only_when_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_req_n |-> !rf_sync);

  // R2
  hidden_steers_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hid |-> (addr_sel && addr_oe && ras_n == acc_stb_n));

  // R6
  ack_starts_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh_req_n && !refresh_ack_n) |=> (!ras_n && addr_sel && refresh_req_n));

  // R7
  row_steps_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row != $past(row)) |-> (row == ROW_W'($past(row) + 1'b1)));

  // R8
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !hid_now && !frc) |-> (ras_n && !addr_oe));

  // R3
  pending_cleared_on_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hid) |-> !pend);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROW_W(ROW_W)) chk (
  .clk(clk), .rst_n(rst_n), .rf_sync(rf_sync), .pend(pend), .hid(hid),
  .hid_now(hid_now), .frc(frc), .cs_n(cs_n), .acc_stb_n(acc_stb_n),
  .refresh_ack_n(refresh_ack_n), .refresh_req_n(refresh_req_n), .row(row),
  .addr_sel(addr_sel), .addr_oe(addr_oe), .ras_n(ras_n)
);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int FC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh_clk = 1'b0, cs_n = 1'b1, acc_stb_n = 1'b1, refresh_ack_n = 1'b1;
  logic refresh_req_n, addr_sel, addr_oe, ras_n;
  logic [6:0] row;
  logic [6:0] exp_row = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dram_refresh_sched #(.ROW_W(7), .FORCE_CYC(FC)) uut (
    .clk(clk), .rst_n(rst_n), .refresh_clk(refresh_clk), .cs_n(cs_n),
    .acc_stb_n(acc_stb_n), .refresh_ack_n(refresh_ack_n),
    .refresh_req_n(refresh_req_n), .row(row), .addr_sel(addr_sel),
    .addr_oe(addr_oe), .ras_n(ras_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic arm_period();
    @(negedge clk) refresh_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic drop_clk();
    @(negedge clk) refresh_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(refresh_req_n == 1'b1, "R1 req_n", refresh_req_n, 1);
    chk(ras_n == 1'b1, "R1 ras_n", ras_n, 1);
    chk(addr_sel == 1'b0 && addr_oe == 1'b0, "R1 sel/oe", {addr_sel, addr_oe}, 0);
    chk(row == 7'd0, "R1 row", row, 0);
  endtask

  task automatic t_hidden();
    arm_period();
    acc_stb_n = 1'b0;
    #1;
    chk(addr_sel && addr_oe, "R2 sel/oe", {addr_sel, addr_oe}, 3);
    chk(ras_n == 1'b0, "R2 ras follows strobe", ras_n, 0);
    @(negedge clk) acc_stb_n = 1'b1;
    #1 chk(ras_n == 1'b1, "R2 ras released", ras_n, 1);
    @(posedge clk) #1;
    exp_row = exp_row + 7'd1;
    chk(row == exp_row, "R7 row after hidden", row, exp_row);
    @(negedge clk) acc_stb_n = 1'b0;
    #1;
    chk(ras_n == 1'b1 && !addr_sel, "R3 second strobe ignored", {ras_n, addr_sel}, 2);
    chk(addr_oe == 1'b0, "R8 deselected oe", addr_oe, 0);
    @(negedge clk) acc_stb_n = 1'b1;
    drop_clk();
    chk(refresh_req_n == 1'b1, "R3 no request after hidden", refresh_req_n, 1);
    chk(row == exp_row, "R3 row unchanged", row, exp_row);
  endtask

  task automatic t_hidden_across_fall();
    arm_period();
    acc_stb_n = 1'b0;
    @(negedge clk) refresh_clk = 1'b0;
    repeat (4) @(negedge clk);
    chk(ras_n == 1'b0 && addr_sel, "R4 hidden continues", {ras_n, addr_sel}, 1);
    chk(refresh_req_n == 1'b1, "R4 no request", refresh_req_n, 1);
    acc_stb_n = 1'b1;
    @(posedge clk) #1;
    exp_row = exp_row + 7'd1;
    chk(row == exp_row, "R7 row after late hidden", row, exp_row);
  endtask

  task automatic t_forced();
    int cnt;
    arm_period();
    chk(refresh_req_n == 1'b1, "R5 no request while high", refresh_req_n, 1);
    @(negedge clk) refresh_clk = 1'b0;
    repeat (3) @(negedge clk);
    chk(refresh_req_n == 1'b0, "R5 request raised", refresh_req_n, 0);
    chk(row == exp_row, "R7 row waits for ack", row, exp_row);
    refresh_ack_n = 1'b0;
    @(posedge clk) #1;
    chk(ras_n == 1'b0 && addr_sel, "R6 forced start", {ras_n, addr_sel}, 1);
    chk(refresh_req_n == 1'b1, "R6 request withdrawn", refresh_req_n, 1);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ras_n == 1'b0) cnt++;
      else break;
    end
    chk(cnt == FC, "R6 forced length", cnt, FC);
    exp_row = exp_row + 7'd1;
    chk(row == exp_row, "R7 row after forced", row, exp_row);
    repeat (2) @(negedge clk);
    chk(refresh_req_n == 1'b1 && ras_n == 1'b1, "R6 single forced", {refresh_req_n, ras_n}, 3);
    refresh_ack_n = 1'b1;
  endtask

  task automatic t_ack_idle();
    @(negedge clk) refresh_ack_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ras_n == 1'b1 && !addr_sel, "R10 stray ack", {ras_n, addr_sel}, 2);
    chk(row == exp_row, "R10 row kept", row, exp_row);
    refresh_ack_n = 1'b1;
  endtask

  task automatic t_normal();
    @(negedge clk) cs_n = 1'b0;
    #1 chk(ras_n == 1'b1 && addr_oe, "R9 idle selected", {ras_n, addr_oe}, 3);
    @(negedge clk) acc_stb_n = 1'b0;
    #1;
    chk(ras_n == 1'b0, "R9 ras follows strobe", ras_n, 0);
    chk(addr_sel == 1'b0 && addr_oe, "R9 sel/oe", {addr_sel, addr_oe}, 1);
    @(negedge clk) acc_stb_n = 1'b1;
    @(negedge clk) cs_n = 1'b1;
    chk(row == exp_row, "R9 no refresh", row, exp_row);
  endtask

  task automatic t_wrap();
    for (int n = 0; n < 200 && !(exp_row == 7'd0 && n > 0); n++) begin
      arm_period();
      acc_stb_n = 1'b0;
      @(negedge clk) acc_stb_n = 1'b1;
      @(posedge clk);
      exp_row = exp_row + 7'd1;
      drop_clk();
    end
    chk(row == 7'd0, "R7 wrap to zero", row, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_hidden();
    t_hidden_across_fall();
    t_forced();
    t_ack_idle();
    t_normal();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule